// File: doc/BRIEF.md
# Hit Latency Pipeline with Dual Clock-Crossing Readout

This block holds the binary hit flags of every strip channel in a fixed-length shift pipeline, so that the flags seen at a bunch crossing are still on hand when the first-level accept decision arrives a fixed number of crossings later. When an accept is asserted, the word leaving the end of the pipeline is written into a raw-data queue. Cluster words from the coincidence selector are written into a separate trigger queue in the same crossing clock domain.

Both queues cross into an independent output clock domain. One output bus carries both streams. A tag bit on the bus marks the source of each word. Trigger words always take precedence over raw words. Each queue has a fixed depth of 16 words. A write to a full queue discards the word and sets an overflow flag that stays set until the next reset. The pipeline length is a parameter. A full-length pipeline of 256 stages and shortened builds such as 135 stages use the same logic.

Top module: `trig_readout_top`

## Requirements
- R1: While reset is held and right after it is released, `bus_valid`, `bus_is_trig` and `bus_data` are 0 and both overflow flags are 0.
- R2: An accept presented at crossing t stores exactly the 128 flags that were presented at crossing t − LATENCY, with bit i of the word equal to channel i.
- R3: Raw words leave the bus in the order of their accepts. None is lost or duplicated while fewer than 16 are pending.
- R4: Trigger words leave the bus in write order with `bus_is_trig` = 1. They are zero-extended into `bus_data[TRIG_W-1:0]`. Raw words carry `bus_is_trig` = 0.
- R5: When both queues hold words at the output side, every pending trigger word is sent before any raw word.
- R6: Each queue holds 16 words. With the output side stalled, the first 16 writes are kept and later writes are dropped.
- R7: A write to a full queue sets that queue's overflow flag (`raw_overflow` or `trig_overflow`). The flag remains 1 until reset, and the other queue's flag is not affected.
- R8: While words are available, one word is sent on every output clock cycle with no idle gaps. When both queues are empty, `bus_valid` is 0.
- R9: An accept and a trigger word presented in the same crossing are both stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bx | input | 1 | Crossing clock; the pipeline and both write sides run on it |
| clk_out | input | 1 | Output bus clock, asynchronous to clk_bx |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| hit_flags | input | GROUPS*GROUP_CH | Per-channel hit flags for the current crossing |
| l1_accept | input | 1 | First-level accept; captures the pipeline output |
| trig_valid | input | 1 | A cluster word is present on trig_word |
| trig_word | input | TRIG_W | Cluster word from the coincidence selector |
| bus_valid | output | 1 | A word is on the output bus this output cycle |
| bus_is_trig | output | 1 | 1 = trigger word, 0 = raw word |
| bus_data | output | GROUPS*GROUP_CH | Output word; trigger words are zero-extended |
| raw_overflow | output | 1 | Sticky: a raw write was dropped (crossing domain) |
| trig_overflow | output | 1 | Sticky: a trigger write was dropped (crossing domain) |

## Verification
The assertions assume the following about the inputs: both clocks run without glitches, reset lasts at least two edges of each clock, and the queue pointers move only through the block's own write and pop decisions. The occupancy bounds therefore hold whenever the gray-coded pointers pass through the two-flop stages one bit at a time. The stimulus sends accepts only after the pipeline has filled for LATENCY crossings, so every captured word is defined. It paces traffic below the drain rate except in the deliberate overflow and priority phases. In those phases the output clock is paused only while both queues are empty.

// File: rtl/rdo_pkg.sv
`timescale 1ns/1ps
package rdo_pkg;

  // Source chosen by the output arbiter for the next bus word.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_TRIG = 2'd1,
    SRC_RAW  = 2'd2
  } src_e;

  localparam int unsigned DEF_GROUPS   = 2;
  localparam int unsigned DEF_GROUP_CH = 64;
  localparam int unsigned DEF_LATENCY  = 256;
  localparam int unsigned DEF_TRIG_W   = 36;
  localparam int unsigned DEF_QDEPTH   = 16;

endpackage

// File: rtl/rdo_rst_sync.sv
`timescale 1ns/1ps
module rdo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] chain_q;
  logic [1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[1];

endmodule

// File: rtl/rdo_latency_line.sv
`timescale 1ns/1ps
module rdo_latency_line #(
  parameter int unsigned W     = 128,
  parameter int unsigned DEPTH = 256
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  // Data-only shift chain: no reset, every stage advances each crossing.
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [W-1:0] q;
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        q <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        q <= g_stage[s-1].q;
      end
    end
  end

  assign dout = g_stage[DEPTH-1].q;

endmodule

// File: rtl/rdo_xdom_fifo.sv
`timescale 1ns/1ps
module rdo_xdom_fifo #(
  parameter int unsigned W     = 128,
  parameter int unsigned DEPTH = 16
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic         full,
  output logic         ovf,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         rd_en,
  output logic [W-1:0] rdata,
  output logic         empty
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [W-1:0]  mem [DEPTH];

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0] r2w_s1, r2w_s2, w2r_s1, w2r_s2;
  logic          ovf_q, ovf_d;
  logic          wr_ok, rd_ok;

  // ---------------- write side ----------------
  assign full  = (wgray_q == {~r2w_s2[PW-1:PW-2], r2w_s2[PW-3:0]});
  assign wr_ok = wr_en && !full;

  always_comb begin
    wbin_d  = wbin_q + PW'(wr_ok);
    wgray_d = wbin_d ^ (wbin_d >> 1);
    ovf_d   = ovf_q | (wr_en & full);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      r2w_s1  <= '0;
      r2w_s2  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      r2w_s1  <= rgray_q;
      r2w_s2  <= r2w_s1;
      ovf_q   <= ovf_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_ok) begin
      mem[wbin_q[AW-1:0]] <= wdata;
    end
  end

  assign ovf = ovf_q;

  // ---------------- read side ----------------
  assign empty = (rgray_q == w2r_s2);
  assign rd_ok = rd_en && !empty;
  assign rdata = mem[rbin_q[AW-1:0]];

  always_comb begin
    rbin_d  = rbin_q + PW'(rd_ok);
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      w2r_s1  <= '0;
      w2r_s2  <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      w2r_s1  <= wgray_q;
      w2r_s2  <= w2r_s1;
    end
  end

  // ---------------- checks ----------------
  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  AST_WR_OCC_BOUND: assert property (@(posedge wclk) disable iff (!wrst_n) (PW'(wbin_q - g2b(r2w_s2)) <= PW'(DEPTH))); // R6
  AST_RD_NO_UNDERRUN: assert property (@(posedge rclk) disable iff (!rrst_n) (PW'(g2b(w2r_s2) - rbin_q) <= PW'(DEPTH))); // R3
  AST_OVF_STICKY: assert property (@(posedge wclk) disable iff (!wrst_n) ovf_q |=> ovf_q); // R7
  AST_FULL_SETS_OVF: assert property (@(posedge wclk) disable iff (!wrst_n) (wr_en && full) |=> ovf); // R7

endmodule

// File: rtl/rdo_out_arbiter.sv
`timescale 1ns/1ps
module rdo_out_arbiter
  import rdo_pkg::*;
#(
  parameter int unsigned TW = 36,
  parameter int unsigned BW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          t_empty,
  input  logic [TW-1:0] t_data,
  input  logic          r_empty,
  input  logic [BW-1:0] r_data,
  output logic          t_pop,
  output logic          r_pop,
  output logic          bus_valid,
  output logic          bus_is_trig,
  output logic [BW-1:0] bus_data
);

  src_e          sel;
  logic          valid_q, valid_d;
  logic          tag_q, tag_d;
  logic [BW-1:0] data_q, data_d;
  logic          data_en;

  // Fixed priority: trigger queue first, raw queue only when it is idle.
  always_comb begin
    if (!t_empty) begin
      sel = SRC_TRIG;
    end else if (!r_empty) begin
      sel = SRC_RAW;
    end else begin
      sel = SRC_NONE;
    end
  end

  assign t_pop = (sel == SRC_TRIG);
  assign r_pop = (sel == SRC_RAW);

  always_comb begin
    valid_d = (sel != SRC_NONE);
    tag_d   = (sel == SRC_TRIG);
    data_en = (sel != SRC_NONE);
    case (sel)
      SRC_TRIG: data_d = BW'(t_data);
      SRC_RAW:  data_d = r_data;
      default:  data_d = data_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      if (data_en) begin
        data_q <= data_d;
      end
    end
  end

  assign bus_valid   = valid_q;
  assign bus_is_trig = tag_q;
  assign bus_data    = data_q;

  AST_TRIG_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (bus_valid && !bus_is_trig) |-> $past(t_empty)); // R5
  AST_VALID_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) bus_valid |-> $past(!t_empty || !r_empty)); // R8
  AST_IDLE_WHEN_DRY: assert property (@(posedge clk) disable iff (!rst_n) $past(t_empty && r_empty) |-> !bus_valid); // R8
  AST_TAG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) bus_is_trig |-> bus_valid); // R4

endmodule

// File: rtl/trig_readout_top.sv
`timescale 1ns/1ps
module trig_readout_top
  import rdo_pkg::*;
#(
  parameter int unsigned GROUPS   = DEF_GROUPS,
  parameter int unsigned GROUP_CH = DEF_GROUP_CH,
  parameter int unsigned LATENCY  = DEF_LATENCY,
  parameter int unsigned TRIG_W   = DEF_TRIG_W,
  parameter int unsigned QDEPTH   = DEF_QDEPTH
) (
  input  logic                         clk_bx,
  input  logic                         clk_out,
  input  logic                         rst_n,
  input  logic [GROUPS*GROUP_CH-1:0]   hit_flags,
  input  logic                         l1_accept,
  input  logic                         trig_valid,
  input  logic [TRIG_W-1:0]            trig_word,
  output logic                         bus_valid,
  output logic                         bus_is_trig,
  output logic [GROUPS*GROUP_CH-1:0]   bus_data,
  output logic                         raw_overflow,
  output logic                         trig_overflow
);

  localparam int unsigned CH = GROUPS * GROUP_CH;

  logic          bx_rst_n, out_rst_n;
  logic [CH-1:0] pipe_tail;
  logic          raw_full, raw_empty, raw_pop;
  logic [CH-1:0] raw_rdata;
  logic          trg_full, trg_empty, trg_pop;
  logic [TRIG_W-1:0] trg_rdata;

  rdo_rst_sync i_bx_rst (
    .clk    (clk_bx),
    .arst_n (rst_n),
    .srst_n (bx_rst_n)
  );

  rdo_rst_sync i_out_rst (
    .clk    (clk_out),
    .arst_n (rst_n),
    .srst_n (out_rst_n)
  );

  rdo_latency_line #(
    .W     (CH),
    .DEPTH (LATENCY)
  ) i_line (
    .clk  (clk_bx),
    .din  (hit_flags),
    .dout (pipe_tail)
  );

  rdo_xdom_fifo #(
    .W     (CH),
    .DEPTH (QDEPTH)
  ) i_raw_q (
    .wclk   (clk_bx),
    .wrst_n (bx_rst_n),
    .wr_en  (l1_accept),
    .wdata  (pipe_tail),
    .full   (raw_full),
    .ovf    (raw_overflow),
    .rclk   (clk_out),
    .rrst_n (out_rst_n),
    .rd_en  (raw_pop),
    .rdata  (raw_rdata),
    .empty  (raw_empty)
  );

  rdo_xdom_fifo #(
    .W     (TRIG_W),
    .DEPTH (QDEPTH)
  ) i_trg_q (
    .wclk   (clk_bx),
    .wrst_n (bx_rst_n),
    .wr_en  (trig_valid),
    .wdata  (trig_word),
    .full   (trg_full),
    .ovf    (trig_overflow),
    .rclk   (clk_out),
    .rrst_n (out_rst_n),
    .rd_en  (trg_pop),
    .rdata  (trg_rdata),
    .empty  (trg_empty)
  );

  rdo_out_arbiter #(
    .TW (TRIG_W),
    .BW (CH)
  ) i_arb (
    .clk         (clk_out),
    .rst_n       (out_rst_n),
    .t_empty     (trg_empty),
    .t_data      (trg_rdata),
    .r_empty     (raw_empty),
    .r_data      (raw_rdata),
    .t_pop       (trg_pop),
    .r_pop       (raw_pop),
    .bus_valid   (bus_valid),
    .bus_is_trig (bus_is_trig),
    .bus_data    (bus_data)
  );

  AST_OVF_ONLY_IF_FULL: assert property (@(posedge clk_bx) disable iff (!bx_rst_n) $rose(raw_overflow) |-> $past(raw_full && l1_accept)); // R7
  AST_RESET_QUIET: assert property (@(posedge clk_out) !out_rst_n |-> (!bus_valid && !bus_is_trig)); // R1

endmodule

// File: tb/test_trig_readout_top.sv
`timescale 1ns/1ps
module test_trig_readout_top;

  localparam int CH  = 128;
  localparam int TW  = 36;
  localparam int LAT = 135;
  localparam int QD  = 16;

  logic          clk_bx = 1'b0;
  logic          clk_out = 1'b0;
  logic          oclk_run = 1'b1;
  logic          rst_n;
  logic [CH-1:0] hit_flags;
  logic          l1_accept;
  logic          trig_valid;
  logic [TW-1:0] trig_word;
  logic          bus_valid;
  logic          bus_is_trig;
  logic [CH-1:0] bus_data;
  logic          raw_overflow;
  logic          trig_overflow;

  int n_chk = 0;
  int n_err = 0;
  int ecount = 0;
  int ocyc = 0;
  bit done = 0;

  logic [CH-1:0] exp_r[$];
  logic [CH-1:0] exp_t[$];
  bit            tag_log[$];
  int            cyc_log[$];

  trig_readout_top #(
    .GROUPS   (2),
    .GROUP_CH (64),
    .LATENCY  (LAT),
    .TRIG_W   (TW),
    .QDEPTH   (QD)
  ) i_trig_readout_top (
    .clk_bx        (clk_bx),
    .clk_out       (clk_out),
    .rst_n         (rst_n),
    .hit_flags     (hit_flags),
    .l1_accept     (l1_accept),
    .trig_valid    (trig_valid),
    .trig_word     (trig_word),
    .bus_valid     (bus_valid),
    .bus_is_trig   (bus_is_trig),
    .bus_data      (bus_data),
    .raw_overflow  (raw_overflow),
    .trig_overflow (trig_overflow)
  );

  always #2.5 clk_bx = ~clk_bx;
  always #7 if (oclk_run) clk_out = ~clk_out;

  function automatic logic [CH-1:0] pat(input int k);
    logic [CH-1:0] v;
    for (int j = 0; j < CH / 32; j++) begin
      v[j*32 +: 32] = (32'(k) + 32'd1) * 32'h9E3779B1 ^ (32'(j) * 32'h01000193) ^ (32'(k) << j);
    end
    return v;
  endfunction

  function automatic logic [TW-1:0] tw(input int i);
    return TW'(36'h9_C0DE_0000 + 36'(i) * 36'h0_0000_0107);
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [CH-1:0] act, input logic [CH-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // Crossing counter: the edge after this negedge has index ecount.
  always @(posedge clk_bx) ecount++;

  always @(negedge clk_bx) hit_flags <= pat(ecount);

  // One crossing of stimulus, with the expected results queued.
  task automatic step(input bit l1, input bit tv, input logic [TW-1:0] w,
                      input bit keep_r, input bit keep_t);
    @(negedge clk_bx);
    l1_accept  = l1;
    trig_valid = tv;
    trig_word  = w;
    if (l1 && keep_r) exp_r.push_back(pat(ecount - LAT));
    if (tv && keep_t) exp_t.push_back(CH'(w));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 4000; i++) begin
      if (exp_r.size() == 0 && exp_t.size() == 0) break;
      idle(1);
    end
    idle(20);
    check(exp_r.size() == 0 && exp_t.size() == 0, req,
          CH'(exp_r.size() + exp_t.size()), '0);
  endtask

  // Monitor / scoreboard on the output side.
  always @(negedge clk_out) begin
    ocyc++;
    if (rst_n && bus_valid) begin
      tag_log.push_back(bus_is_trig);
      cyc_log.push_back(ocyc);
      if (bus_is_trig) begin
        if (exp_t.size() == 0) begin
          check(1'b0, "R4 unexpected trigger word", bus_data, '0);
        end else begin
          logic [CH-1:0] e;
          e = exp_t.pop_front();
          check(bus_data == e, "R4 trigger word", bus_data, e);
        end
      end else begin
        if (exp_r.size() == 0) begin
          check(1'b0, "R3 unexpected raw word", bus_data, '0);
        end else begin
          logic [CH-1:0] e;
          e = exp_r.pop_front();
          check(bus_data == e, "R2 R3 raw word", bus_data, e);
        end
      end
    end
  end

  initial begin
    #900000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    int base;
    bit order_ok;
    rst_n      = 1'b0;
    l1_accept  = 1'b0;
    trig_valid = 1'b0;
    trig_word  = '0;
    repeat (6) @(negedge clk_bx);
    // R1: quiet during reset
    check(bus_valid == 1'b0 && bus_is_trig == 1'b0, "R1 bus in reset", CH'({bus_valid, bus_is_trig}), '0);
    check(bus_data == '0, "R1 data in reset", bus_data, '0);
    rst_n = 1'b1;
    idle(8);
    check({raw_overflow, trig_overflow} == 2'b00, "R1 overflow flags", CH'({raw_overflow, trig_overflow}), '0);
    check(bus_valid == 1'b0, "R1 bus after reset", CH'(bus_valid), '0);

    // fill the latency line
    idle(LAT + 4);

    // Paced traffic: R2 R3 R4 R9
    for (int i = 0; i < 12; i++) begin
      step(1'b1, (i % 2) == 0, tw(i), 1'b1, 1'b1);
      idle(5);
    end
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b1, tw(100 + i), 1'b1, 1'b1);
      idle(4);
    end
    drain("R3 paced traffic drained");

    // Priority and back-to-back output: R5 R8
    oclk_run = 1'b0;
    idle(10);
    base = tag_log.size();
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, tw(200 + i), 1'b1, 1'b1);
    idle(10);
    oclk_run = 1'b1;
    drain("R5 burst drained");
    check(tag_log.size() - base == 16, "R5 burst word count", CH'(tag_log.size() - base), CH'(16));
    if (tag_log.size() - base == 16) begin
      order_ok = 1'b1;
      for (int i = 0; i < 16; i++) begin
        if (tag_log[base + i] != (i < 8)) order_ok = 1'b0;
      end
      check(order_ok, "R5 trigger words before raw", CH'(order_ok), CH'(1));
      check(cyc_log[base + 15] - cyc_log[base] == 15, "R8 no idle gaps",
            CH'(cyc_log[base + 15] - cyc_log[base]), CH'(15));
    end

    // Trigger queue overflow: R6 R7
    oclk_run = 1'b0;
    idle(10);
    for (int i = 0; i < 18; i++) step(1'b0, 1'b1, tw(300 + i), 1'b0, i < QD);
    idle(4);
    check(trig_overflow == 1'b1, "R7 trigger overflow set", CH'(trig_overflow), CH'(1));
    check(raw_overflow == 1'b0, "R7 raw flag unaffected", CH'(raw_overflow), '0);
    oclk_run = 1'b1;
    drain("R6 only 16 trigger words kept");

    // Raw queue overflow, sticky trigger flag: R6 R7
    oclk_run = 1'b0;
    idle(10);
    for (int i = 0; i < 17; i++) step(1'b1, 1'b0, '0, i < QD, 1'b0);
    idle(4);
    check(raw_overflow == 1'b1, "R7 raw overflow set", CH'(raw_overflow), CH'(1));
    check(trig_overflow == 1'b1, "R7 trigger flag sticky", CH'(trig_overflow), CH'(1));
    oclk_run = 1'b1;
    drain("R6 only 16 raw words kept");
    check(raw_overflow == 1'b1, "R7 raw flag sticky", CH'(raw_overflow), CH'(1));

    // Idle bus: R8
    repeat (5) @(negedge clk_out);
    check(bus_valid == 1'b0, "R8 idle when empty", CH'(bus_valid), '0);

    finish_sim();
  end

endmodule